// File: doc/BRIEF.md
# Return Address Stack with Repair

This block holds predicted return addresses for a branch-prediction front end, with one independent circular stack for each hardware thread. A thread select input chooses which stack receives a command and which stack drives the outputs. A predicted call pushes a return address that the caller supplies. A predicted return pops the stack. The caller reads the top value as its predicted target, and reads the top index, in the same cycle as the pop, so that it can keep both for a later repair.

When the pipeline discovers that it went down a wrong path, the caller has two ways to recover. It issues a repair, which forces the top pointer back to a saved index and rewrites that slot with a saved target, undoing wrong-path returns exactly. It issues an undo, which removes one speculative push. The stack never stalls. A push onto a full stack overwrites the oldest entry. A pop on an empty stack leaves the occupancy at zero and exposes whatever the slot held before.

Top module: `ret_addr_stack`

## Requirements
- R1: Synchronous active-high reset sets the top index and the occupancy count of every thread to 0.
- R2: `top_idx_o`, `top_val_o` and `count_o` show the selected thread's top pointer, the slot it points at, and its occupancy, combinationally from `tid_i`. Before a pop is applied they show the pre-pop top.
- R3: A push moves the selected thread's top index to (index+1) modulo DEPTH, writes `push_addr_i` into that slot, and raises the count by one.
- R4: A push while the count equals DEPTH overwrites the oldest slot and leaves the count at DEPTH.
- R5: A pop moves the top index to (index-1) modulo DEPTH, with 0 wrapping to DEPTH-1, and lowers the count by one.
- R6: A pop with count 0 still moves the index, leaves the count at 0, and leaves the slot contents untouched, so the stale value is shown.
- R7: `undo_i` removes one speculative push with exactly the effect of a pop. Asserting both pop and undo gives a single decrement.
- R8: A repair sets the top index to `repair_idx_i` and writes `repair_tgt_i` into that slot. The count does not change. `repair_idx_i` must be below DEPTH.
- R9: Priority is repair, then push, then pop/undo. When several are asserted together, only the highest of them takes effect.
- R10: Commands act only on the thread that `tid_i` selects. Every other thread's index, count and contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tid_i | input | TID_W | Thread select for command and outputs |
| push_i | input | 1 | Push a return address |
| push_addr_i | input | ADDR_W | Return address to push |
| pop_i | input | 1 | Pop for a predicted return |
| undo_i | input | 1 | Undo one speculative push |
| repair_i | input | 1 | Restore saved index and target |
| repair_idx_i | input | PTR_W | Saved top index |
| repair_tgt_i | input | ADDR_W | Saved top value |
| top_idx_o | output | PTR_W | Selected thread's top index |
| top_val_o | output | ADDR_W | Selected thread's top value |
| count_o | output | CNT_W | Selected thread's occupancy |

## Verification
The bench goes after several corner cases:
- The pointer wrapping in both directions. A design that got this wrong would index past the last slot or fail to return to slot 0.
- A push onto a full stack. A design that got this wrong would let the count grow past the depth or stall.
- Pops on an empty stack. A design that got this wrong would wrap the count to its maximum or would wipe the stale slot.
- Repair combined with push and pop in the same cycle. A design that got this wrong would apply the lower-priority command or double-update the pointer.
- A second thread interleaved with the first. A design that got this wrong would show cross-thread corruption, with a command leaking into a stack that was not selected.

// File: rtl/ras_pkg.sv
package ras_pkg;

   typedef enum logic [1:0] {
      RAS_HOLD   = 2'd0,
      RAS_PUSH   = 2'd1,
      RAS_POP    = 2'd2,
      RAS_REPAIR = 2'd3
   } ras_op_e;

endpackage

// File: rtl/ras_cmd_dec.sv
module ras_cmd_dec
   import ras_pkg::*;
(
   input  logic    push_i,
   input  logic    pop_i,
   input  logic    undo_i,
   input  logic    repair_i,
   output ras_op_e op_o
);

   // repair outranks push, push outranks pop/undo
   always_comb begin
      if (repair_i)            op_o = RAS_REPAIR;
      else if (push_i)         op_o = RAS_PUSH;
      else if (pop_i | undo_i) op_o = RAS_POP;
      else                     op_o = RAS_HOLD;
   end

endmodule

// File: rtl/ras_ptr.sv
module ras_ptr
   import ras_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sel_i,
   input  ras_op_e          op_i,
   input  logic [PTR_W-1:0] repair_idx_i,
   output logic [PTR_W-1:0] tos_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] wr_idx_o
);

   localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [PTR_W-1:0] tos_q, tos_inc, tos_dec, tos_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   generate
      if (IS_POW2) begin : g_wrap_pow2
         assign tos_inc = tos_q + PTR_W'(1);
         assign tos_dec = tos_q - PTR_W'(1);
      end else begin : g_wrap_cmp
         assign tos_inc = (tos_q == PTR_W'(DEPTH - 1)) ? '0 : tos_q + PTR_W'(1);
         assign tos_dec = (tos_q == '0) ? PTR_W'(DEPTH - 1) : tos_q - PTR_W'(1);
      end
   endgenerate

   always_comb begin
      tos_d    = tos_q;
      cnt_d    = cnt_q;
      wr_en_o  = 1'b0;
      wr_idx_o = tos_inc;
      if (sel_i) begin
         unique case (op_i)
            RAS_PUSH: begin
               tos_d    = tos_inc;
               wr_en_o  = 1'b1;
               wr_idx_o = tos_inc;
               if (cnt_q != CNT_W'(DEPTH)) cnt_d = cnt_q + CNT_W'(1);
            end
            RAS_POP: begin
               tos_d = tos_dec;
               if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
            end
            RAS_REPAIR: begin
               tos_d    = repair_idx_i;
               wr_en_o  = 1'b1;
               wr_idx_o = repair_idx_i;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tos_q <= '0;
         cnt_q <= '0;
      end else begin
         tos_q <= tos_d;
         cnt_q <= cnt_d;
      end
   end

   assign tos_o = tos_q;
   assign cnt_o = cnt_q;

endmodule

// File: rtl/ras_store.sv
module ras_store #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [PTR_W-1:0]  widx_i,
   input  logic [ADDR_W-1:0] wdata_i,
   input  logic [PTR_W-1:0]  ridx_i,
   output logic [ADDR_W-1:0] rdata_o
);

   logic [ADDR_W-1:0] slot_q [DEPTH];

   // contents are data only, never reset
   always_ff @(posedge clk) begin
      if (we_i) slot_q[widx_i] <= wdata_i;
   end

   assign rdata_o = slot_q[ridx_i];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
   import ras_pkg::*;
#(
   parameter int NUM_THREADS = 2,
   parameter int DEPTH       = 8,
   parameter int ADDR_W      = 32,
   localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TID_W-1:0]  tid_i,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   input  logic              pop_i,
   input  logic              undo_i,
   input  logic              repair_i,
   input  logic [PTR_W-1:0]  repair_idx_i,
   input  logic [ADDR_W-1:0] repair_tgt_i,
   output logic [PTR_W-1:0]  top_idx_o,
   output logic [ADDR_W-1:0] top_val_o,
   output logic [CNT_W-1:0]  count_o
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ret_addr_stack: DEPTH must be at least 2");
      end
      if (NUM_THREADS < 1) begin : g_bad_threads
         $error("ret_addr_stack: NUM_THREADS must be at least 1");
      end
      if (ADDR_W < 1) begin : g_bad_width
         $error("ret_addr_stack: ADDR_W must be at least 1");
      end
   endgenerate

   ras_op_e           op;
   logic [ADDR_W-1:0] wdata;

   ras_cmd_dec u_dec (
      .push_i   (push_i),
      .pop_i    (pop_i),
      .undo_i   (undo_i),
      .repair_i (repair_i),
      .op_o     (op)
   );

   assign wdata = (op == RAS_REPAIR) ? repair_tgt_i : push_addr_i;

   logic [PTR_W-1:0]  tos_a [NUM_THREADS];
   logic [CNT_W-1:0]  cnt_a [NUM_THREADS];
   logic [ADDR_W-1:0] val_a [NUM_THREADS];

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
         logic             sel;
         logic             we;
         logic [PTR_W-1:0] widx;

         assign sel = (tid_i == TID_W'(t));

         ras_ptr #(.DEPTH(DEPTH)) u_ptr (
            .clk          (clk),
            .rst          (rst),
            .sel_i        (sel),
            .op_i         (op),
            .repair_idx_i (repair_idx_i),
            .tos_o        (tos_a[t]),
            .cnt_o        (cnt_a[t]),
            .wr_en_o      (we),
            .wr_idx_o     (widx)
         );

         ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
            .clk     (clk),
            .we_i    (we),
            .widx_i  (widx),
            .wdata_i (wdata),
            .ridx_i  (tos_a[t]),
            .rdata_o (val_a[t])
         );
      end
   endgenerate

   always_comb begin
      top_idx_o = '0;
      top_val_o = '0;
      count_o   = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         if (tid_i == TID_W'(t)) begin
            top_idx_o = tos_a[t];
            top_val_o = val_a[t];
            count_o   = cnt_a[t];
         end
      end
   end

endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
   parameter int NUM_THREADS = 2,
   parameter int DEPTH       = 8,
   parameter int ADDR_W      = 32,
   localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic [TID_W-1:0]  tid_i,
   input logic              push_i,
   input logic [ADDR_W-1:0] push_addr_i,
   input logic              pop_i,
   input logic              undo_i,
   input logic              repair_i,
   input logic [PTR_W-1:0]  repair_idx_i,
   input logic [ADDR_W-1:0] repair_tgt_i,
   input logic [PTR_W-1:0]  top_idx_o,
   input logic [ADDR_W-1:0] top_val_o,
   input logic [CNT_W-1:0]  count_o
);

   logic [PTR_W-1:0] idx_up, idx_down;
   assign idx_up   = (top_idx_o == PTR_W'(DEPTH - 1)) ? '0 : top_idx_o + PTR_W'(1);
   assign idx_down = (top_idx_o == '0) ? PTR_W'(DEPTH - 1) : top_idx_o - PTR_W'(1);

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (top_idx_o == '0 && count_o == '0)); // R1

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      count_o <= CNT_W'(DEPTH)); // R3

   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
      (push_i && !repair_i) |=> (tid_i != $past(tid_i)) ||
         (top_idx_o == $past(idx_up) && top_val_o == $past(push_addr_i))); // R3

   AST_FULL_SAT: assert property (@(posedge clk) disable iff (rst)
      (push_i && !repair_i && count_o == CNT_W'(DEPTH)) |=>
         (tid_i != $past(tid_i)) || (count_o == CNT_W'(DEPTH))); // R4

   AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
      ((pop_i || undo_i) && !push_i && !repair_i) |=>
         (tid_i != $past(tid_i)) || (top_idx_o == $past(idx_down))); // R5

   AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
      ((pop_i || undo_i) && !push_i && !repair_i && count_o == '0) |=>
         (tid_i != $past(tid_i)) || (count_o == '0)); // R6

   AST_REPAIR_LOAD: assert property (@(posedge clk) disable iff (rst)
      repair_i |=> (tid_i != $past(tid_i)) ||
         (top_idx_o == $past(repair_idx_i) && top_val_o == $past(repair_tgt_i))); // R8

   AST_REPAIR_FIRST: assert property (@(posedge clk) disable iff (rst)
      (repair_i && (push_i || pop_i || undo_i)) |=>
         (tid_i != $past(tid_i)) || (count_o == $past(count_o))); // R9

   AST_REPAIR_IDX_OK: assert property (@(posedge clk) disable iff (rst)
      repair_i |-> (repair_idx_i <= PTR_W'(DEPTH - 1))); // R8

endmodule

bind ret_addr_stack ret_addr_stack_chk #(
   .NUM_THREADS (NUM_THREADS),
   .DEPTH       (DEPTH),
   .ADDR_W      (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .tid_i        (tid_i),
   .push_i       (push_i),
   .push_addr_i  (push_addr_i),
   .pop_i        (pop_i),
   .undo_i       (undo_i),
   .repair_i     (repair_i),
   .repair_idx_i (repair_idx_i),
   .repair_tgt_i (repair_tgt_i),
   .top_idx_o    (top_idx_o),
   .top_val_o    (top_val_o),
   .count_o      (count_o)
);

// File: tb/ret_addr_stack_tb.sv
module ret_addr_stack_tb;

   localparam int NT = 2;
   localparam int DP = 4;
   localparam int AW = 16;
   localparam int NV = 17;

   typedef struct packed {
      logic        tid;
      logic        push;
      logic        pop;
      logic        undo;
      logic        repair;
      logic [15:0] addr;
      logic [1:0]  ridx;
      logic [15:0] rtgt;
      logic [1:0]  e_idx;
      logic [15:0] e_val;
      logic [2:0]  e_cnt;
      logic [7:0]  req;
   } vec_t;

   // expected values are the selected thread's state one cycle after the command
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h1000,2'd0,16'h0000,2'd1,16'h1000,3'd1,8'd3},  // R3 push
      '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h1004,2'd0,16'h0000,2'd2,16'h1004,3'd2,8'd3},  // R3
      '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h1008,2'd0,16'h0000,2'd3,16'h1008,3'd3,8'd3},  // R3
      '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h100C,2'd0,16'h0000,2'd0,16'h100C,3'd4,8'd3},  // R3 wrap up
      '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h1010,2'd0,16'h0000,2'd1,16'h1010,3'd4,8'd4},  // R4 full
      '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,2'd0,16'h0000,2'd0,16'h100C,3'd3,8'd5},  // R5 pop
      '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,2'd0,16'h0000,2'd3,16'h1008,3'd2,8'd5},  // R5 wrap down
      '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h2000,2'd0,16'h0000,2'd1,16'h2000,3'd1,8'd10}, // R10 thread 1
      '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,2'd0,16'h0000,2'd3,16'h1008,3'd2,8'd10}, // R10 t0 intact
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,2'd1,16'h3333,2'd1,16'h3333,3'd2,8'd8},  // R8 repair
      '{1'b0,1'b1,1'b1,1'b0,1'b1,16'h4444,2'd2,16'h5555,2'd2,16'h5555,3'd2,8'd9},  // R9 priority
      '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,2'd0,16'h0000,2'd1,16'h3333,3'd1,8'd7},  // R7 undo
      '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h0000,2'd0,16'h0000,2'd0,16'h100C,3'd0,8'd7},  // R7 pop+undo once
      '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,2'd0,16'h0000,2'd3,16'h1008,3'd0,8'd6},  // R6 empty pop
      '{1'b0,1'b1,1'b1,1'b0,1'b0,16'h6666,2'd0,16'h0000,2'd0,16'h6666,3'd1,8'd9},  // R9 push over pop
      '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h2004,2'd0,16'h0000,2'd2,16'h2004,3'd2,8'd10}, // R10
      '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,2'd0,16'h0000,2'd2,16'h2004,3'd2,8'd2}   // R2 hold
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tid = 1'b0;
   logic          push = 1'b0, pop = 1'b0, undo = 1'b0, repair = 1'b0;
   logic [AW-1:0] push_addr = '0, repair_tgt = '0;
   logic [1:0]    repair_idx = '0;
   logic [1:0]    top_idx;
   logic [AW-1:0] top_val;
   logic [2:0]    count;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   ret_addr_stack #(.NUM_THREADS(NT), .DEPTH(DP), .ADDR_W(AW)) u_dut (
      .clk          (clk),
      .rst          (rst),
      .tid_i        (tid),
      .push_i       (push),
      .push_addr_i  (push_addr),
      .pop_i        (pop),
      .undo_i       (undo),
      .repair_i     (repair),
      .repair_idx_i (repair_idx),
      .repair_tgt_i (repair_tgt),
      .top_idx_o    (top_idx),
      .top_val_o    (top_val),
      .count_o      (count)
   );

   task automatic check(input int req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      push = 1'b0; pop = 1'b0; undo = 1'b0; repair = 1'b0;
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      // R1: reset state on both threads
      tid = 1'b0; #0;
      check(1, "t0 idx after reset", 32'(top_idx), 32'd0);
      check(1, "t0 cnt after reset", 32'(count), 32'd0);
      tid = 1'b1; #1;
      check(1, "t1 cnt after reset", 32'(count), 32'd0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         tid        = VEC[i].tid;
         push       = VEC[i].push;
         pop        = VEC[i].pop;
         undo       = VEC[i].undo;
         repair     = VEC[i].repair;
         push_addr  = VEC[i].addr;
         repair_idx = VEC[i].ridx;
         repair_tgt = VEC[i].rtgt;
         @(negedge clk);
         idle();
         #1;
         check(int'(VEC[i].req), $sformatf("vec %0d idx", i), 32'(top_idx), 32'(VEC[i].e_idx));
         check(int'(VEC[i].req), $sformatf("vec %0d val", i), 32'(top_val), 32'(VEC[i].e_val));
         check(int'(VEC[i].req), $sformatf("vec %0d cnt", i), 32'(count), 32'(VEC[i].e_cnt));
      end

      // R2: pre-pop top is visible in the cycle of the pop (t1 top is 2004 at idx 2)
      tid = 1'b1; pop = 1'b1; #1;
      check(2, "pre-pop top value", 32'(top_val), 32'h2004);
      check(2, "pre-pop top index", 32'(top_idx), 32'd2);
      @(negedge clk);
      idle(); #1;
      check(5, "t1 after pop idx", 32'(top_idx), 32'd1);

      // R1: reset in mid-run clears the thread that had state
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0; tid = 1'b0; #1;
      check(1, "t0 idx after mid reset", 32'(top_idx), 32'd0);
      check(1, "t0 cnt after mid reset", 32'(count), 32'd0);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 2000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule